// File: doc/BRIEF.md
# Multi-Pass EPROM Programming Sequencer

This controller writes a full image into a UV-erasable memory device by sweeping the whole address range repeatedly, not by retrying each byte in turn. When a start command arrives it first reads every address to make sure the device can still take the image. A device that has already been partly written is fine. The only condition is that every bit the image wants at 1 still reads 1. It then alternates program passes and verify passes. A program pass asks an external pulse generator for one programming pulse per byte that still holds a 1 where the image wants a 0. A verify pass rereads the whole device and classifies every bit. The run ends when all bits match, or when damage is seen, or when the allowed number of program passes is used up.

For each address the controller drives one address bus, `mem_addr`. It expects two answers in the same cycle: the image byte on `exp_data` and the device contents on `mem_rdata`. A pulse request holds its address and data steady until the pulse generator acknowledges it.

The states are:

| State | Role |
|---|---|
| IDLE | Waits for `start`. |
| BLANK | Blank-check sweep. |
| PROG | Program-pass scan; moves to PULSE when a byte needs a pulse. |
| PULSE | Holds the pulse request until `prog_ack`. |
| VERIFY | Reread sweep that classifies each byte. |
| FINISH | One cycle that reports the result. |

The transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | BLANK | `start` |
| BLANK | FINISH | A bit wanted at 1 reads 0. Result is needs-erase. |
| BLANK | PROG | The last address is clean. |
| PROG | PULSE | The byte needs a pulse. |
| PROG | VERIFY | The last address needs no pulse. |
| PULSE | PROG | `prog_ack` at an address below the last. |
| PULSE | VERIFY | `prog_ack` at the last address. |
| VERIFY | FINISH | A bit wanted at 1 reads 0. Result is damage. |
| VERIFY | PROG | Bits are still pending and the pass limit is not reached. |
| VERIFY | FINISH | Bits are still pending at the limit. Result is worn out. |
| VERIFY | FINISH | Nothing is pending. Result is success. |
| FINISH | IDLE | Always. |

Top module: `eprom_pass_programmer`

## Requirements
- R1: After reset, `busy`, `done` and `prog_req` are all low.
- R2: The blank-check sweep flags a byte when `exp_data & ~mem_rdata` is non-zero. The run then ends with result code 2'b01 (needs erase), and no pulse has been requested.
- R3: The blank check accepts a device that is not fully erased, provided every bit wanted at 1 reads 1. Such a device then completes with result 2'b00.
- R4: A program pass requests a pulse only for bytes where `mem_rdata & ~exp_data` is non-zero. It visits them in ascending address order, with `prog_data` equal to the image byte. Bytes whose image is 0xFF are never pulsed.
- R5: `prog_req` stays high, with `mem_addr` and `prog_data` unchanged, until `prog_ack` is sampled high. Each acknowledge ends exactly one pulse.
- R6: If a verify sweep finds a bit wanted at 1 that reads 0, the run ends with result 2'b10 (damage).
- R7: If a verify sweep finds bits wanted at 0 that still read 1, another program pass runs. At most MAX_PASSES (default 10) program passes run in total. A run that still has pending bits after the last allowed pass ends with result 2'b11 (worn out).
- R8: A verify sweep that finds every byte equal to the image ends the run with result 2'b00 (success). This includes an image that needs exactly MAX_PASSES passes and a device that needs no pulses at all.
- R9: `done` is a single-cycle pulse that carries a valid `result`. `busy` is high from the cycle after `start` until `done`, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a programming run when idle |
| mem_addr | output | ADDR_W | Address shared by the image lookup, device read and pulse request |
| exp_data | input | DATA_W | Image byte at `mem_addr` |
| mem_rdata | input | DATA_W | Device contents at `mem_addr` |
| prog_req | output | 1 | Pulse request for the byte at `mem_addr` |
| prog_data | output | DATA_W | Byte to program |
| prog_ack | input | 1 | Pulse generator finished the pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| result | output | 2 | 00 success, 01 needs erase, 10 damage, 11 worn out |

## Verification
The bench targets five corner cases:

- **Partly written but compatible device.** A design that demanded an all-ones device would wrongly report needs-erase here.
- **Image with 0xFF bytes.** A design that pulsed blindly would show extra requests.
- **Byte needing exactly the pass limit.** An off-by-one pass counter would call it worn out.
- **Byte that never takes.** Here the counter must stop at the limit rather than loop.
- **Pulse that clears a bit wanted at 1.** This must be reported as damage and not as pending work.

A reference model of the device and of the sweep order predicts every pulse address in sequence. Skipped, reordered or repeated pulses are therefore caught at the cycle they are requested.

// File: rtl/ep_prog_pkg.sv
package ep_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLANK,
        ST_PROG,
        ST_PULSE,
        ST_VERIFY,
        ST_FINISH
    } ep_state_t;

    typedef enum logic [1:0] {
        RES_OK     = 2'b00,
        RES_ERASE  = 2'b01,
        RES_DAMAGE = 2'b10,
        RES_WORN   = 2'b11
    } ep_result_t;

endpackage

// File: rtl/ep_byte_class.sv
// Per-bit classification of one device byte against its image byte.
module ep_byte_class #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] img_byte,
    input  logic [DATA_W-1:0] dev_byte,
    output logic              needs_pulse,
    output logic              lost_one
);
    logic [DATA_W-1:0] still_one;
    logic [DATA_W-1:0] stuck_zero;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        // bit must still fall from 1 to 0
        assign still_one[b]  = dev_byte[b] & ~img_byte[b];
        // bit wanted high already reads low
        assign stuck_zero[b] = img_byte[b] & ~dev_byte[b];
    end

    assign needs_pulse = |still_one;
    assign lost_one    = |stuck_zero;
endmodule

// File: rtl/ep_addr_sweep.sv
// Address counter for whole-array sweeps.
module ep_addr_sweep #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   addr <= '0;
        else if (clr) addr <= '0;
        else if (inc) addr <= addr + 1'b1;
    end

    assign at_last = (addr == LAST_ADDR);
endmodule

// File: rtl/ep_pass_counter.sv
// Counts program passes; the first pass is number one.
module ep_pass_counter #(
    parameter int MAX_PASSES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_PASSES + 1);

    logic [CW-1:0] pass_no;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pass_no <= CW'(1);
        else if (clr) pass_no <= CW'(1);
        else if (inc) pass_no <= pass_no + 1'b1;
    end

    assign at_limit = (pass_no == CW'(MAX_PASSES));

    // R7
    pass_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit)
        else $error("pass counter advanced past the limit");
endmodule

// File: rtl/eprom_pass_programmer.sv
module eprom_pass_programmer
    import ep_prog_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int MAX_PASSES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] exp_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              prog_req,
    output logic [DATA_W-1:0] prog_data,
    input  logic              prog_ack,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    ep_state_t  state, state_nx;
    ep_result_t res_q, res_nx;
    logic       pend_q, pend_nx;

    logic addr_clr, addr_inc, at_last;
    logic pass_clr, pass_inc, at_limit;
    logic needs_pulse, lost_one;

    ep_byte_class #(.DATA_W(DATA_W)) u_class (
        .img_byte    (exp_data),
        .dev_byte    (mem_rdata),
        .needs_pulse (needs_pulse),
        .lost_one    (lost_one)
    );

    ep_addr_sweep #(.ADDR_W(ADDR_W)) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .inc     (addr_inc),
        .addr    (mem_addr),
        .at_last (at_last)
    );

    ep_pass_counter #(.MAX_PASSES(MAX_PASSES)) u_pass (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pass_clr),
        .inc      (pass_inc),
        .at_limit (at_limit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            res_q  <= RES_OK;
            pend_q <= 1'b0;
        end else begin
            state  <= state_nx;
            res_q  <= res_nx;
            pend_q <= pend_nx;
        end
    end

    // transitions and sweep control
    always_comb begin
        state_nx = state;
        res_nx   = res_q;
        pend_nx  = pend_q;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        pass_clr = 1'b0;
        pass_inc = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_BLANK;
                    addr_clr = 1'b1;
                    pass_clr = 1'b1;
                end
            end
            ST_BLANK: begin
                if (lost_one) begin
                    res_nx   = RES_ERASE;
                    state_nx = ST_FINISH;
                end else if (at_last) begin
                    state_nx = ST_PROG;
                    addr_clr = 1'b1;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            ST_PROG: begin
                if (needs_pulse) begin
                    state_nx = ST_PULSE;
                end else if (at_last) begin
                    state_nx = ST_VERIFY;
                    addr_clr = 1'b1;
                    pend_nx  = 1'b0;
                end else begin
                    addr_inc = 1'b1;
                end
            end
            ST_PULSE: begin
                if (prog_ack) begin
                    if (at_last) begin
                        state_nx = ST_VERIFY;
                        addr_clr = 1'b1;
                        pend_nx  = 1'b0;
                    end else begin
                        state_nx = ST_PROG;
                        addr_inc = 1'b1;
                    end
                end
            end
            ST_VERIFY: begin
                if (lost_one) begin
                    res_nx   = RES_DAMAGE;
                    state_nx = ST_FINISH;
                end else if (at_last) begin
                    if (pend_q || needs_pulse) begin
                        if (at_limit) begin
                            res_nx   = RES_WORN;
                            state_nx = ST_FINISH;
                        end else begin
                            pass_inc = 1'b1;
                            addr_clr = 1'b1;
                            state_nx = ST_PROG;
                        end
                    end else begin
                        res_nx   = RES_OK;
                        state_nx = ST_FINISH;
                    end
                end else begin
                    addr_inc = 1'b1;
                    if (needs_pulse) pend_nx = 1'b1;
                end
            end
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prog_req  = (state == ST_PULSE);
        prog_data = exp_data;
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        result    = res_q;
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !prog_ack) |=> prog_req)
        else $error("pulse request dropped before acknowledge");

    // R5
    req_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && !prog_ack) |=> $stable(mem_addr))
        else $error("address moved during pulse request");

    // R4
    no_ff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> (prog_data != {DATA_W{1'b1}}))
        else $error("pulse requested for an all-ones byte");

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy))
        else $error("done longer than one cycle");

    // R2
    erase_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK) |-> !prog_req)
        else $error("pulse during blank check");
endmodule

// File: tb/tb_eprom_pass_programmer.sv
module tb_eprom_pass_programmer;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;
    localparam int MP = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] exp_data, mem_rdata, prog_data;
    logic          prog_req, prog_ack = 1'b0;
    logic          busy, done;
    logic [1:0]    result;

    logic [DW-1:0] img [N];
    logic [DW-1:0] dev [N];
    logic [DW-1:0] corr [N];
    int            need [N];

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    bit req_seen = 1'b0;
    int wait_cnt = 0;
    string cur_tag = "";

    always #10 clk = ~clk;

    assign exp_data  = img[mem_addr];
    assign mem_rdata = dev[mem_addr];

    eprom_pass_programmer #(.ADDR_W(AW), .DATA_W(DW), .MAX_PASSES(MP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_addr(mem_addr), .exp_data(exp_data), .mem_rdata(mem_rdata),
        .prog_req(prog_req), .prog_data(prog_data), .prog_ack(prog_ack),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input string tag, input int actual, input int expected, input string what);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, actual, expected);
        end
    endtask

    // device model: a byte takes its value only on the pulse that uses up its need
    function automatic logic [DW-1:0] after_pulse(logic [DW-1:0] cur, logic [DW-1:0] d,
                                                  int remaining, logic [DW-1:0] c);
        logic [DW-1:0] v;
        v = (remaining == 1) ? (cur & d) : cur;
        return v & ~c;
    endfunction

    // pulse generator and per-clock pulse order compare (R4, R5)
    always @(negedge clk) begin
        if (prog_req && !prog_ack) begin
            if (!req_seen) begin
                req_seen = 1'b1;
                wait_cnt = 0;
                if (exp_q.size() == 0) begin
                    check("R4", int'(mem_addr), -1, "unexpected pulse");
                end else begin
                    int a;
                    a = exp_q.pop_front();
                    check("R4", int'(mem_addr), a, "pulse address");
                    check("R4", int'(prog_data), int'(img[a]), "pulse data");
                end
            end else begin
                wait_cnt++;
                check("R5", int'(prog_req), 1, "request held");
            end
            if (wait_cnt == 2) begin
                prog_ack = 1'b1;
                dev[mem_addr] = after_pulse(dev[mem_addr], prog_data, need[mem_addr], corr[mem_addr]);
                if (need[mem_addr] > 0) need[mem_addr]--;
            end
        end else begin
            prog_ack = 1'b0;
            req_seen = 1'b0;
        end
    end

    // reference sweep model: fills exp_q and returns the result code
    function automatic int model_run();
        logic [DW-1:0] m [N];
        logic [DW-1:0] p [N];
        int   n [N];
        int   pass;
        bit   pending;
        for (int a = 0; a < N; a++) begin
            m[a] = dev[a];
            n[a] = need[a];
            p[a] = img[a];
        end
        for (int a = 0; a < N; a++)
            if ((p[a] & ~m[a]) != 0) return 1;
        pass = 1;
        forever begin
            for (int a = 0; a < N; a++) begin
                if ((m[a] & ~p[a]) != 0) begin
                    exp_q.push_back(a);
                    m[a] = after_pulse(m[a], p[a], n[a], corr[a]);
                    if (n[a] > 0) n[a]--;
                end
            end
            pending = 1'b0;
            for (int a = 0; a < N; a++) begin
                if ((p[a] & ~m[a]) != 0) return 2;
                if ((m[a] & ~p[a]) != 0) pending = 1'b1;
            end
            if (!pending) return 0;
            if (pass == MP) return 3;
            pass++;
        end
    endfunction

    task automatic base_setup();
        for (int a = 0; a < N; a++) begin
            img[a]  = ((a % 4) == 3) ? 8'hFF : 8'(a * 37 + 5);
            dev[a]  = 8'hFF;
            corr[a] = 8'h00;
            need[a] = 1;
        end
    endtask

    task automatic run_case(input string tag, input int want_res);
        int res;
        int cyc;
        exp_q.delete();
        res = model_run();
        check(tag, res, want_res, "model outcome");
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", int'(busy), 1, "busy after start");
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            check(tag, 0, 1, "watchdog expired");
        end else begin
            check(tag, int'(result), res, "result code");
            check("R4", exp_q.size(), 0, "pulses left unissued");
            @(negedge clk);
            check("R9", int'(done), 0, "done single cycle");
            check("R9", int'(busy), 0, "busy after done");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(busy), 0, "busy in reset");
        check("R1", int'(done), 0, "done in reset");
        check("R1", int'(prog_req), 0, "req in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(busy), 0, "busy idle");

        // R8: erased device, image with 0xFF bytes (R4 skip)
        base_setup();
        run_case("R8", 0);

        // R3: partly written but compatible device
        base_setup();
        for (int a = 0; a < N; a += 2) dev[a] = img[a];
        dev[5] = img[5] | 8'hF0;
        run_case("R3", 0);

        // R2: a wanted 1 already reads 0
        base_setup();
        dev[9] = img[9] & ~8'h02;
        run_case("R2", 1);

        // R7: bytes needing several passes
        base_setup();
        for (int a = 0; a < N; a++) need[a] = 1 + (a % 3);
        run_case("R7", 0);

        // R8: exactly the pass limit
        base_setup();
        need[2] = MP;
        run_case("R8", 0);

        // R7: byte never takes -> worn out
        base_setup();
        need[4] = 99;
        run_case("R7", 3);

        // R6: pulse clears a wanted 1
        base_setup();
        corr[6] = 8'h40;
        run_case("R6", 2);

        // R8: already programmed, no pulses
        base_setup();
        for (int a = 0; a < N; a++) dev[a] = img[a];
        run_case("R8", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule